// File: doc/BRIEF.md
# Single-channel peripheral-to-memory DMA with stop and resume

This block is one DMA channel that copies data items from a fixed peripheral data address into a run of incrementing memory addresses. A peripheral raises a request whenever it holds an item. The channel acknowledges the request, reads the item and then writes it to memory. Software programs the channel through a small register port. It loads a peripheral address, a memory start address and an item count, then sets the enable bit. In one-shot mode the channel stops after the count. In circular mode it reloads the count and start address and keeps going.

Software can halt a running channel by clearing enable. Clearing enable does not stop the channel on the spot. An item whose peripheral read has already been issued still lands in memory, and enable keeps reading as 1 until that has happened. The counter then holds the number of items still owed. Software may rewrite the addresses and the count and set enable again to continue. A sticky transfer-complete flag, which also drives the interrupt output, is raised at every normal end, at every circular wrap and at every early stop.

Top module: `dmach_top`

## Requirements
- R1: After reset every register reads 0, and `per_ack`, `mem_we` and `tc_irq` are low. Register offsets are: 0 control (bit0 enable/busy, bit1 circular), 1 status (bit0 transfer-complete, write 1 to clear), 2 peripheral address, 3 memory address, 4 remaining count. A read issued with `reg_rd` appears on `reg_rdata` in the following cycle.
- R2: While enabled and waiting, a sampled `per_req` produces a one-cycle `per_ack` in the next cycle. The peripheral supplies `per_rdata` in the cycle after `per_ack`. That item is presented on `mem_we`/`mem_addr`/`mem_wdata` one cycle later, which is two cycles after `per_ack`.
- R3: Each item is written to the current memory address, which then grows by STEP (4) bytes. `per_addr` stays at the programmed peripheral address.
- R4: In one-shot mode (control bit1 = 0), after the programmed count has been written the channel goes idle. Enable reads 0, the count reads 0, and later requests get no acknowledge.
- R5: In circular mode (control bit1 = 1), after the last item of a pass the count and memory address reload from the values last written to them, and the channel stays enabled.
- R6: Writing 0 to control bit0 while an item is in flight lets that item complete to memory. Enable reads 1 until then and 0 afterwards, and the count holds exactly the items not yet written.
- R7: Writing 0 to control bit0 while the channel waits with no request stops it at that edge. No acknowledge follows and the count is unchanged.
- R8: If the stop write and a request fall in the same cycle while the channel waits, the stop wins. No acknowledge is given and no item is moved.
- R9: The transfer-complete flag is set at each one-shot end, each circular wrap and each stop. It stays set until status bit0 is written with 1. If a clear and a setting event fall in the same cycle, the flag ends up set.
- R10: While enable reads 1, writes to the peripheral address, memory address, count and circular bit have no effect.
- R11: After a stop, rewriting the memory address and count and setting enable again continues the transfer from the new address for the new count.
- R12: Setting enable while the count is 0 is ignored, and enable keeps reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| per_req | input | 1 | Peripheral has an item ready |
| per_ack | output | 1 | Request taken; the peripheral read is issued |
| per_addr | output | AW | Peripheral data address |
| per_rdata | input | DW | Peripheral item, valid the cycle after `per_ack` |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| tc_irq | output | 1 | Sticky transfer-complete flag |

## Verification
Two pairs of events can land on the same edge. The first is a software stop and a peripheral request while the channel is waiting. The bench raises the request and writes the stop in the very next cycle, then expects no acknowledge, an unchanged count and a set flag. The second is a write-one-to-clear of the flag on the edge where the last one-shot item completes. The bench waits for the final acknowledge, issues the clear in the following cycle, and expects the flag to read set. Every item the channel writes is compared against a scoreboard of expected address and data pairs.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_XFER  = 2'd2,
    ST_CAPT  = 2'd3
  } dmach_state_t;

  localparam int          RAW       = 3;
  localparam logic [2:0]  OFF_CTRL  = 3'd0;
  localparam logic [2:0]  OFF_STAT  = 3'd1;
  localparam logic [2:0]  OFF_PADDR = 3'd2;
  localparam logic [2:0]  OFF_MADDR = 3'd3;
  localparam logic [2:0]  OFF_COUNT = 3'd4;

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int RW = 32,
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [RAW-1:0] reg_addr,
  input  logic [RW-1:0]  reg_wdata,
  output logic [RW-1:0]  reg_rdata,
  input  logic           busy_i,
  input  logic [AW-1:0]  maddr_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic           fin_i,
  output logic [AW-1:0]  paddr_o,
  output logic [AW-1:0]  sh_maddr_o,
  output logic [CW-1:0]  sh_cnt_o,
  output logic           circ_o,
  output logic           start_o,
  output logic           stop_o,
  output logic           ld_maddr_o,
  output logic           ld_cnt_o,
  output logic           tc_o
);

  logic wr_ctrl, wr_stat, wr_paddr;

  assign wr_ctrl    = reg_wr && (reg_addr == OFF_CTRL);
  assign wr_stat    = reg_wr && (reg_addr == OFF_STAT);
  assign wr_paddr   = reg_wr && (reg_addr == OFF_PADDR) && !busy_i;
  assign ld_maddr_o = reg_wr && (reg_addr == OFF_MADDR) && !busy_i;
  assign ld_cnt_o   = reg_wr && (reg_addr == OFF_COUNT) && !busy_i;
  assign start_o    = wr_ctrl && reg_wdata[0] && !busy_i && (cnt_i != '0);
  assign stop_o     = wr_ctrl && !reg_wdata[0] && busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      paddr_o    <= '0;
      sh_maddr_o <= '0;
      sh_cnt_o   <= '0;
      circ_o     <= 1'b0;
      tc_o       <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      if (wr_paddr)   paddr_o    <= reg_wdata[AW-1:0];
      if (ld_maddr_o) sh_maddr_o <= reg_wdata[AW-1:0];
      if (ld_cnt_o)   sh_cnt_o   <= reg_wdata[CW-1:0];
      if (wr_ctrl && !busy_i) circ_o <= reg_wdata[1];
      // a completion event outranks a same-cycle clear
      if (fin_i)                       tc_o <= 1'b1;
      else if (wr_stat && reg_wdata[0]) tc_o <= 1'b0;
      if (reg_rd) begin
        case (reg_addr)
          OFF_CTRL:  reg_rdata <= RW'({circ_o, busy_i});
          OFF_STAT:  reg_rdata <= RW'(tc_o);
          OFF_PADDR: reg_rdata <= RW'(paddr_o);
          OFF_MADDR: reg_rdata <= RW'(maddr_i);
          OFF_COUNT: reg_rdata <= RW'(cnt_i);
          default:   reg_rdata <= '0;
        endcase
      end
    end
  end

  // R9: completion always leaves the flag set
  a_r9_tc_set_on_fin: assert property (@(posedge clk) disable iff (rst)
    fin_i |=> tc_o);

  // R10: programming of the peripheral address is frozen while running
  a_r10_paddr_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(busy_i) |-> $stable(paddr_o));

endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
  import dmach_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          circ_i,
  input  logic          ld_maddr_i,
  input  logic          ld_cnt_i,
  input  logic [AW-1:0] wr_val_i,
  input  logic [AW-1:0] sh_maddr_i,
  input  logic [CW-1:0] sh_cnt_i,
  input  logic          per_req_i,
  input  logic [DW-1:0] per_rdata_i,
  output logic          busy_o,
  output logic [AW-1:0] maddr_o,
  output logic [CW-1:0] cnt_o,
  output logic          per_ack_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          fin_o
);

  localparam logic [AW-1:0] ADDR_STEP = AW'(STEP);
  localparam logic [CW-1:0] CNT_ONE   = CW'(1);

  dmach_state_t st;
  logic stop_pend, stopping, last, wrap;

  assign busy_o   = (st != ST_IDLE);
  assign stopping = stop_i || stop_pend;
  assign last     = (cnt_o == CNT_ONE);
  assign wrap     = (st == ST_CAPT) && last && circ_i && !stopping;
  assign fin_o    = ((st == ST_ARMED) && stop_i) ||
                    ((st == ST_CAPT) && (last || stopping));

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      stop_pend   <= 1'b0;
      maddr_o     <= '0;
      cnt_o       <= '0;
      per_ack_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      per_ack_o <= 1'b0;
      mem_we_o  <= 1'b0;
      if (ld_maddr_i) maddr_o <= wr_val_i;
      if (ld_cnt_i)   cnt_o   <= wr_val_i[CW-1:0];
      case (st)
        ST_IDLE: begin
          stop_pend <= 1'b0;
          if (start_i) st <= ST_ARMED;
        end
        ST_ARMED: begin
          if (stop_i) begin
            st <= ST_IDLE;
          end else if (per_req_i) begin
            per_ack_o <= 1'b1;
            st        <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (stop_i) stop_pend <= 1'b1;
          st <= ST_CAPT;
        end
        default: begin
          mem_we_o    <= 1'b1;
          mem_addr_o  <= maddr_o;
          mem_wdata_o <= per_rdata_i;
          stop_pend   <= 1'b0;
          if (wrap) begin
            maddr_o <= sh_maddr_i;
            cnt_o   <= sh_cnt_i;
            st      <= ST_ARMED;
          end else begin
            maddr_o <= maddr_o + ADDR_STEP;
            cnt_o   <= cnt_o - CNT_ONE;
            st      <= (last || stopping) ? ST_IDLE : ST_ARMED;
          end
        end
      endcase
    end
  end

  // R2: a memory write is always two cycles behind its acknowledge
  a_r2_write_after_ack: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> $past(per_ack_o, 2));

  // R3: address advance by one item when no wrap happens
  a_r3_maddr_step: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CAPT && !wrap) |=> (maddr_o == $past(maddr_o) + ADDR_STEP));

  // R4: an idle channel never acknowledges
  a_r4_idle_no_ack: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> !per_ack_o);

  // R6: a stop seen with an item in flight keeps the channel busy
  a_r6_inflight_holds: assert property (@(posedge clk) disable iff (rst)
    (stop_i && st == ST_XFER) |=> busy_o);

  // R8: a stop in the waiting state wins over a request
  a_r8_stop_beats_req: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ARMED && stop_i) |=> (!per_ack_o && !busy_o));

endmodule

// File: rtl/dmach_top.sv
module dmach_top
  import dmach_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int STEP = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           per_req,
  output logic           per_ack,
  output logic [AW-1:0]  per_addr,
  input  logic [DW-1:0]  per_rdata,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           tc_irq
);

  localparam int RW = 32;

  logic          busy, fin, circ, start, stop, ld_maddr, ld_cnt;
  logic [AW-1:0] maddr, sh_maddr;
  logic [CW-1:0] cnt, sh_cnt;

  dmach_regs #(.RW(RW), .AW(AW), .CW(CW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy_i     (busy),
    .maddr_i    (maddr),
    .cnt_i      (cnt),
    .fin_i      (fin),
    .paddr_o    (per_addr),
    .sh_maddr_o (sh_maddr),
    .sh_cnt_o   (sh_cnt),
    .circ_o     (circ),
    .start_o    (start),
    .stop_o     (stop),
    .ld_maddr_o (ld_maddr),
    .ld_cnt_o   (ld_cnt),
    .tc_o       (tc_irq)
  );

  dmach_engine #(.AW(AW), .DW(DW), .CW(CW), .STEP(STEP)) u_eng (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .stop_i      (stop),
    .circ_i      (circ),
    .ld_maddr_i  (ld_maddr),
    .ld_cnt_i    (ld_cnt),
    .wr_val_i    (reg_wdata[AW-1:0]),
    .sh_maddr_i  (sh_maddr),
    .sh_cnt_i    (sh_cnt),
    .per_req_i   (per_req),
    .per_rdata_i (per_rdata),
    .busy_o      (busy),
    .maddr_o     (maddr),
    .cnt_o       (cnt),
    .per_ack_o   (per_ack),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .fin_o       (fin)
  );

endmodule

// File: tb/dmach_top_test.sv
module dmach_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        per_req, per_ack, mem_we, tc_irq;
  logic [31:0] per_addr, mem_addr, mem_wdata;
  logic [31:0] per_rdata = '0;

  int tests = 0, fails = 0;
  int pending = 0, req_add = 0, ack_cnt = 0;
  bit req_clr = 1'b0, ack_d1 = 1'b0, ack_d2 = 1'b0, done = 1'b0;
  logic [31:0] seq = 32'hA500_0000, dseq = 32'hA500_0000;
  logic [31:0] cur_paddr = '0;
  logic [63:0] exp_q[$];
  logic [31:0] rv;

  always #2 clk = ~clk;

  dmach_top uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .per_req(per_req), .per_ack(per_ack), .per_addr(per_addr),
    .per_rdata(per_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .tc_irq(tc_irq)
  );

  assign per_req = (pending != 0);

  // peripheral model: data follows each acknowledge by one cycle
  always @(posedge clk) begin
    if (req_clr) pending <= 0;
    else pending <= pending + req_add - (per_ack ? 1 : 0);
    if (per_ack) begin
      per_rdata <= seq;
      seq <= seq + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop and ordering checks
  always @(negedge clk) begin
    if (!rst) begin
      if (per_ack) begin
        ack_cnt++;
        chk("R3 per_addr", per_addr, cur_paddr);
      end
      if (mem_we) begin
        chk("R2 ack-to-write", 32'(ack_d2), 32'd1);
        if (exp_q.size() == 0) begin
          chk("R2 unexpected write", mem_addr, 32'hFFFF_FFFF);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk("R3 mem_addr", mem_addr, e[63:32]);
          chk("R2 mem_wdata", mem_wdata, e[31:0]);
        end
      end
      ack_d2 = ack_d1;
      ack_d1 = per_ack;
    end
  end

  task automatic push_items(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({base + 32'(4 * i), dseq});
      dseq = dseq + 1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic add_req(input int n);
    @(negedge clk);
    req_add = n;
    @(negedge clk);
    req_add = 0;
  endtask

  task automatic clr_req();
    @(negedge clk);
    req_clr = 1'b1;
    @(negedge clk);
    req_clr = 1'b0;
  endtask

  task automatic wait_ack();
    do @(negedge clk); while (!per_ack);
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int k;
    k = 0;
    do begin
      rd(3'd0, v);
      k++;
    end while (v[0] && k < 500);
    chk({req, " reached idle"}, 32'(v[0]), 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int acks0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), rv);
      chk("R1 reset reg", rv, 32'd0);
    end
    chk("R1 outputs low", {29'd0, per_ack, mem_we, tc_irq}, 32'd0);

    // R12 zero count start ignored
    wr(3'd0, 32'd1);
    rd(3'd0, rv);
    chk("R12 enable with zero count", rv, 32'd0);

    // R2 R3 R4 one-shot of five
    cur_paddr = 32'h4000_0010;
    wr(3'd2, cur_paddr);
    wr(3'd3, 32'h0000_1000);
    wr(3'd4, 32'd5);
    push_items(32'h1000, 5);
    wr(3'd0, 32'd1);
    rd(3'd0, rv);
    chk("R2 enable reads set", rv, 32'd1);
    add_req(5);
    wait_idle("R4");
    rd(3'd4, rv);  chk("R4 count zero", rv, 32'd0);
    rd(3'd3, rv);  chk("R3 final maddr", rv, 32'h0000_1014);
    rd(3'd1, rv);  chk("R9 tc after one-shot", rv, 32'd1);
    chk("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);
    acks0 = ack_cnt;
    add_req(1);
    repeat (10) @(negedge clk);
    chk("R4 no ack after end", 32'(ack_cnt), 32'(acks0));
    clr_req();

    // R9 clear
    wr(3'd1, 32'd1);
    rd(3'd1, rv);  chk("R9 w1c clears", rv, 32'd0);

    // R10 ignored writes, then R7 stop while waiting
    cur_paddr = 32'h4000_0020;
    wr(3'd2, cur_paddr);
    wr(3'd3, 32'h0000_7000);
    wr(3'd4, 32'd8);
    wr(3'd0, 32'd1);
    wr(3'd4, 32'd3);
    wr(3'd3, 32'h0000_9999);
    wr(3'd2, 32'h0000_DEAD);
    wr(3'd0, 32'd3);
    rd(3'd4, rv);  chk("R10 count locked", rv, 32'd8);
    rd(3'd3, rv);  chk("R10 maddr locked", rv, 32'h0000_7000);
    rd(3'd2, rv);  chk("R10 paddr locked", rv, cur_paddr);
    rd(3'd0, rv);  chk("R10 circ locked", rv, 32'd1);
    acks0 = ack_cnt;
    wr(3'd0, 32'd0);
    rd(3'd0, rv);  chk("R7 stopped at once", rv, 32'd0);
    rd(3'd4, rv);  chk("R7 count kept", rv, 32'd8);
    rd(3'd1, rv);  chk("R9 tc on stop", rv, 32'd1);
    chk("R7 no ack", 32'(ack_cnt), 32'(acks0));
    wr(3'd1, 32'd1);

    // R6 stop with item in flight
    wr(3'd3, 32'h0000_2000);
    wr(3'd4, 32'd6);
    push_items(32'h2000, 3);
    wr(3'd0, 32'd1);
    add_req(3);
    wait_ack(); wait_ack(); wait_ack();
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'd0;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = 3'd0;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R6 enable still set in flight", reg_rdata, 32'd1);
    repeat (3) @(negedge clk);
    rd(3'd0, rv);  chk("R6 enable clear after item", rv, 32'd0);
    rd(3'd4, rv);  chk("R6 remaining count", rv, 32'd3);
    rd(3'd3, rv);  chk("R6 maddr after stop", rv, 32'h0000_200C);
    rd(3'd1, rv);  chk("R6 tc on early stop", rv, 32'd1);
    chk("R6 in-flight item written", 32'(exp_q.size()), 32'd0);
    wr(3'd1, 32'd1);

    // R11 resume at a new address
    wr(3'd3, 32'h0000_3000);
    wr(3'd4, 32'd3);
    push_items(32'h3000, 3);
    wr(3'd0, 32'd1);
    add_req(3);
    wait_idle("R11");
    rd(3'd4, rv);  chk("R11 count zero", rv, 32'd0);
    rd(3'd3, rv);  chk("R11 maddr", rv, 32'h0000_300C);
    chk("R11 scoreboard drained", 32'(exp_q.size()), 32'd0);
    wr(3'd1, 32'd1);

    // R8 stop and request in the same cycle
    wr(3'd4, 32'd4);
    wr(3'd0, 32'd1);
    acks0 = ack_cnt;
    @(negedge clk); req_add = 1;
    @(negedge clk); req_add = 0;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'd0;
    @(negedge clk); reg_wr = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 no ack", 32'(ack_cnt), 32'(acks0));
    rd(3'd4, rv);  chk("R8 count kept", rv, 32'd4);
    rd(3'd0, rv);  chk("R8 stopped", rv, 32'd0);
    clr_req();
    wr(3'd1, 32'd1);

    // R5 circular: count 3, seven items, then stop
    wr(3'd3, 32'h0000_5000);
    wr(3'd4, 32'd3);
    push_items(32'h5000, 3);
    push_items(32'h5000, 3);
    push_items(32'h5000, 1);
    wr(3'd0, 32'd3);
    add_req(7);
    repeat (60) @(negedge clk);
    rd(3'd0, rv);  chk("R5 still enabled", rv, 32'd3);
    rd(3'd4, rv);  chk("R5 reloaded count", rv, 32'd2);
    rd(3'd3, rv);  chk("R5 reloaded maddr", rv, 32'h0000_5004);
    rd(3'd1, rv);  chk("R5 tc on wrap", rv, 32'd1);
    chk("R5 scoreboard drained", 32'(exp_q.size()), 32'd0);
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd1);

    // R9 clear colliding with final item completion
    wr(3'd3, 32'h0000_6000);
    wr(3'd4, 32'd2);
    push_items(32'h6000, 2);
    wr(3'd0, 32'd1);
    add_req(2);
    wait_ack(); wait_ack();
    wr(3'd1, 32'd1);
    repeat (3) @(negedge clk);
    rd(3'd1, rv);  chk("R9 set beats clear", rv, 32'd1);
    rd(3'd0, rv);  chk("R4 idle after collision", rv, 32'd0);
    chk("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);

    finish_run();
  end

endmodule